// File: doc/BRIEF.md
# Segment Selector Descriptor Loader

This block runs when a new 16-bit selector is written into a segment register. It does not treat the selector as a shifted base. It treats it as a pointer into one of two in-memory descriptor tables. Bit 2 of the selector chooses between a table shared by all programs and a per-application table. The upper 13 bits pick an 8-byte entry, and the two low bits carry the requested privilege level.

The loader first confirms that the whole entry lies inside the chosen table's 16-bit limit. It then reads the entry from memory as two 32-bit words over a request/valid port. It unpacks base, limit, access byte and flag bits into a hidden descriptor cache, so that later segment references need no memory traffic.

A fault pulse is raised when the entry lies past the table limit, or when the fetched descriptor is marked not present. In both cases the cache keeps its old contents. A selector write that arrives while a load is in flight is dropped.

The control is a three-state machine:
- `ST_IDLE` waits for a selector write. Two transitions leave it:
  - `IDLE->RD_LO` is taken when the entry is in range.
  - `IDLE->IDLE` with a fault is taken when the entry is out of range.
- `ST_RD_LO` requests the low word. `RD_LO->RD_HI` is taken when the read is valid.
- `ST_RD_HI` requests the high word. Two transitions leave it:
  - `RD_HI->IDLE` with a load is taken when the present bit is 1.
  - `RD_HI->IDLE` with a fault is taken when the present bit is 0.

Top module: `seg_desc_loader`

## Requirements
- R1: Selector bits [15:3] are the entry index, bit 2 selects the table (0 = global pair `gtab_*`, 1 = local pair `ltab_*`), and bits [1:0] are the requested privilege level. After a successful load `seg_sel` holds the full selector that was written.
- R2: The low descriptor word is read first, at table base + index*8. The high word is read next, at table base + index*8 + 4.
- R3: When index*8+7 exceeds the selected 16-bit table limit, `fault` is high for exactly the cycle after the write. No memory request is made, `busy` stays low, and every cache output keeps its value.
- R4: `mem_req` and `mem_addr` hold steady until `mem_rvalid` is sampled high, for any read latency.
- R5: `busy` is high from the cycle after an accepted write until the cycle in which `load_done` or `fault` appears. In that cycle it is low.
- R6: Descriptor bit layout:
  - limit[15:0] is in bits 15:0.
  - base[23:0] is in bits 39:16.
  - The access byte is in bits 47:40.
  - limit[19:16] is in bits 51:48.
  - base[31:24] is in bits 63:56.
  - `seg_flags` = {bit55 granularity, bit54 default-size, bit53, bit52 available}.
- R7: `seg_limit_eff` is {limit, 12'hFFF} when the granularity flag is 1, and the zero-extended 20-bit limit otherwise.
- R8: `seg_dpl` is access bits [6:5]. When access bit 7 (present) is 0, `fault` pulses the cycle after the high word is accepted, and the cache is unchanged.
- R9: A selector write made while `busy` is high has no effect on the running load, on the cache, or on later memory requests. This includes a write in the same cycle the high word completes.
- R10: After reset, `busy`, `mem_req`, `fault` and `load_done` are low, and all cache outputs are zero.
- R11: `load_done` pulses for one cycle in the same cycle the new cache values appear. It never coincides with `fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_wr | input | 1 | Selector write strobe |
| sel_in | input | 16 | Selector value being written |
| gtab_base | input | 32 | Global table base address |
| gtab_limit | input | 16 | Global table limit (last valid byte offset) |
| ltab_base | input | 32 | Local table base address |
| ltab_limit | input | 16 | Local table limit |
| mem_req | output | 1 | Read request, held until accepted |
| mem_addr | output | 32 | Read byte address |
| mem_rvalid | input | 1 | Read data valid; accepts the request |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Load in progress |
| fault | output | 1 | One-cycle fault pulse |
| load_done | output | 1 | One-cycle cache-updated pulse |
| seg_sel | output | 16 | Cached selector |
| seg_base | output | 32 | Cached segment base |
| seg_limit | output | 20 | Cached raw limit |
| seg_limit_eff | output | 32 | Limit scaled by granularity |
| seg_access | output | 8 | Cached access byte |
| seg_dpl | output | 2 | Descriptor privilege level |
| seg_flags | output | 4 | {granularity, default-size, bit53, available} |

## Verification
The two functions that can meet in one cycle are a fresh selector write and completion of the high-word read that fills the cache.

The bench provokes the overlap by watching at each falling edge for `mem_rvalid` together with the high-word address. In that cycle it raises `sel_wr` with a different selector.

The collision is judged correct if four things hold:
- `load_done` still appears.
- `seg_sel` carries the original selector.
- `busy` falls.
- No new `mem_req` follows.

A second directed case drops a write into the middle of a slow load.

// File: rtl/segld_pkg.sv
package segld_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RD_LO = 2'd1,
        ST_RD_HI = 2'd2
    } ld_state_e;

    typedef struct packed {
        logic [31:0] base;
        logic [19:0] limit;
        logic [7:0]  access;
        logic [3:0]  flags;
    } seg_cache_t;
endpackage

// File: rtl/segld_sel_check.sv
module segld_sel_check #(
    parameter int SEL_W  = 16,
    parameter int ADDR_W = 32,
    parameter int TLIM_W = 16
) (
    input  logic [SEL_W-1:2]  sel_hi,
    input  logic [ADDR_W-1:0] gbase,
    input  logic [TLIM_W-1:0] glimit,
    input  logic [ADDR_W-1:0] lbase,
    input  logic [TLIM_W-1:0] llimit,
    output logic [ADDR_W-1:0] entry_addr,
    output logic              in_range
);
    localparam int IDX_W = SEL_W - 3;

    logic [IDX_W-1:0]  idx;
    logic              use_local;
    logic [ADDR_W-1:0] tbl_base;
    logic [TLIM_W-1:0] tbl_lim;
    logic [IDX_W+2:0]  last_byte;

    always_comb begin
        idx        = sel_hi[SEL_W-1:3];
        use_local  = sel_hi[2];
        tbl_base   = use_local ? lbase  : gbase;
        tbl_lim    = use_local ? llimit : glimit;
        last_byte  = {idx, 3'b111};
        in_range   = ADDR_W'(last_byte) <= ADDR_W'(tbl_lim);
        entry_addr = tbl_base + ADDR_W'({idx, 3'b000});
    end
endmodule

// File: rtl/segld_unpack.sv
module segld_unpack
    import segld_pkg::*;
(
    input  logic [63:0] raw,
    output seg_cache_t  fields
);
    always_comb begin
        fields.base   = {raw[63:56], raw[39:16]};
        fields.limit  = {raw[51:48], raw[15:0]};
        fields.access = raw[47:40];
        fields.flags  = raw[55:52];
    end
endmodule

// File: rtl/segld_limit_scale.sv
module segld_limit_scale #(
    parameter int LIM_W  = 20,
    parameter int OUT_W  = 32
) (
    input  logic [LIM_W-1:0] limit,
    input  logic             gran,
    output logic [OUT_W-1:0] eff
);
    localparam int PAD_W = OUT_W - LIM_W;

    always_comb begin
        if (gran)
            eff = {limit, {PAD_W{1'b1}}};
        else
            eff = {{PAD_W{1'b0}}, limit};
    end
endmodule

// File: rtl/seg_desc_loader.sv
module seg_desc_loader
    import segld_pkg::*;
#(
    parameter int SEL_W  = 16,
    parameter int ADDR_W = 32,
    parameter int TLIM_W = 16,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic [ADDR_W-1:0] gtab_base,
    input  logic [TLIM_W-1:0] gtab_limit,
    input  logic [ADDR_W-1:0] ltab_base,
    input  logic [TLIM_W-1:0] ltab_limit,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              fault,
    output logic              load_done,
    output logic [SEL_W-1:0]  seg_sel,
    output logic [31:0]       seg_base,
    output logic [19:0]       seg_limit,
    output logic [31:0]       seg_limit_eff,
    output logic [7:0]        seg_access,
    output logic [1:0]        seg_dpl,
    output logic [3:0]        seg_flags
);
    localparam int PRESENT_BIT = 15;
    localparam int HI_OFFSET   = WORD_W / 8;

    ld_state_e         state;
    logic [SEL_W-1:0]  sel_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] lo_q;
    seg_cache_t        cache_q;
    seg_cache_t        fetched;
    logic [ADDR_W-1:0] entry_addr;
    logic              in_range;
    logic              hi_present;

    segld_sel_check #(.SEL_W(SEL_W), .ADDR_W(ADDR_W), .TLIM_W(TLIM_W)) u_check (
        .sel_hi     (sel_in[SEL_W-1:2]),
        .gbase      (gtab_base),
        .glimit     (gtab_limit),
        .lbase      (ltab_base),
        .llimit     (ltab_limit),
        .entry_addr (entry_addr),
        .in_range   (in_range)
    );

    segld_unpack u_unpack (
        .raw    ({mem_rdata, lo_q}),
        .fields (fetched)
    );

    segld_limit_scale #(.LIM_W(20), .OUT_W(32)) u_scale (
        .limit (cache_q.limit),
        .gran  (cache_q.flags[3]),
        .eff   (seg_limit_eff)
    );

    assign hi_present = mem_rdata[PRESENT_BIT];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (sel_wr && in_range) state <= ST_RD_LO;
                ST_RD_LO: if (mem_rvalid)         state <= ST_RD_HI;
                ST_RD_HI: if (mem_rvalid)         state <= ST_IDLE;
                default:                          state <= ST_IDLE;
            endcase
        end
    end

    // Datapath and cache registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q     <= '0;
            addr_q    <= '0;
            lo_q      <= '0;
            cache_q   <= '0;
            seg_sel   <= '0;
            fault     <= 1'b0;
            load_done <= 1'b0;
        end else begin
            fault     <= 1'b0;
            load_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (sel_wr) begin
                        if (in_range) begin
                            sel_q  <= sel_in;
                            addr_q <= entry_addr;
                        end else begin
                            fault <= 1'b1;
                        end
                    end
                end
                ST_RD_LO: if (mem_rvalid) lo_q <= mem_rdata;
                ST_RD_HI: begin
                    if (mem_rvalid) begin
                        if (hi_present) begin
                            cache_q   <= fetched;
                            seg_sel   <= sel_q;
                            load_done <= 1'b1;
                        end else begin
                            fault <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req  = 1'b0;
        mem_addr = addr_q;
        busy     = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_RD_LO: begin
                mem_req = 1'b1;
                busy    = 1'b1;
            end
            ST_RD_HI: begin
                mem_req  = 1'b1;
                busy     = 1'b1;
                mem_addr = addr_q + ADDR_W'(HI_OFFSET);
            end
            default: ;
        endcase
        seg_base   = cache_q.base;
        seg_limit  = cache_q.limit;
        seg_access = cache_q.access;
        seg_dpl    = cache_q.access[6:5];
        seg_flags  = cache_q.flags;
    end

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    assert_fault_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!busy && !mem_req && $stable(seg_base) && $stable(seg_sel)));

    assert_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sel_wr) |=> (sel_q == $past(sel_q)));

    assert_done_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_done && fault));

    assert_busy_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> !busy);
endmodule

// File: tb/seg_desc_loader_tb.sv
module seg_desc_loader_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] GBASE = 32'h0002_0000;
    localparam logic [31:0] LBASE = 32'h0005_0000;
    localparam logic [15:0] GLIM  = 16'h003F;
    localparam logic [15:0] LLIM  = 16'h00FF;
    localparam int NVEC = 10;
    // {selector, read latency}
    localparam logic [19:0] VEC [0:NVEC-1] = '{
        {16'h0000, 4'd0}, {16'h000B, 4'd1}, {16'h0038, 4'd3}, {16'h0040, 4'd0},
        {16'h0018, 4'd1}, {16'h0015, 4'd2}, {16'h00FE, 4'd0}, {16'h0104, 4'd0},
        {16'h006C, 4'd2}, {16'h0034, 4'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_wr = 1'b0;
    logic [15:0] sel_in = '0;
    logic        mem_req, mem_rvalid = 1'b0;
    logic [31:0] mem_addr, mem_rdata = '0;
    logic        busy, fault, load_done;
    logic [15:0] seg_sel;
    logic [31:0] seg_base, seg_limit_eff;
    logic [19:0] seg_limit;
    logic [7:0]  seg_access;
    logic [1:0]  seg_dpl;
    logic [3:0]  seg_flags;

    int checks = 0;
    int fails = 0;
    int mem_lat = 0;
    int lat_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_desc_loader u_dut (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_in(sel_in),
        .gtab_base(GBASE), .gtab_limit(GLIM), .ltab_base(LBASE), .ltab_limit(LLIM),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(busy), .fault(fault), .load_done(load_done), .seg_sel(seg_sel),
        .seg_base(seg_base), .seg_limit(seg_limit), .seg_limit_eff(seg_limit_eff),
        .seg_access(seg_access), .seg_dpl(seg_dpl), .seg_flags(seg_flags)
    );

    function automatic logic [63:0] make_desc(input logic tbl, input logic [12:0] idx);
        logic [31:0] b;
        logic [19:0] l;
        logic [7:0]  acc;
        logic        pres;
        b    = 32'hA000_0000 ^ ({19'd0, idx} * 32'h0001_0203) ^ (tbl ? 32'h0F00_0000 : 32'h0);
        l    = {idx[3:0], 4'h0, idx[11:0]};
        pres = (idx % 5) != 3;
        acc  = {pres, idx[4:3] ^ {1'b0, tbl}, 5'b10010};
        return {b[31:24], idx[0], idx[1], idx[3], idx[2], l[19:16], acc, b[23:0], l[15:0]};
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic        tbl;
        logic [31:0] off;
        logic [63:0] d;
        tbl = a >= LBASE;
        off = a - (tbl ? LBASE : GBASE);
        d   = make_desc(tbl, off[15:3]);
        return off[2] ? d[63:32] : d[31:0];
    endfunction

    always @(negedge clk) begin
        if (mem_rvalid) begin
            mem_rvalid <= 1'b0;
            lat_cnt    <= 0;
        end else if (mem_req) begin
            if (lat_cnt >= mem_lat) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem_word(mem_addr);
                lat_cnt    <= 0;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
        #1;
    endtask

    // Writes a selector and follows the load to completion, checking every stage.
    task automatic run_load(input logic [15:0] sel, input int lat);
        logic        tbl, rng_bad, pres;
        logic [12:0] idx;
        logic [31:0] ent;
        logic [63:0] d;
        logic [15:0] old_sel;
        logic [31:0] old_base;
        logic [19:0] lim;
        logic        got_done, got_fault;
        tbl = sel[2];
        idx = sel[15:3];
        ent = (tbl ? LBASE : GBASE) + {16'd0, idx, 3'b000};
        rng_bad = {3'b000, idx, 3'b111} > {16'd0, (tbl ? LLIM : GLIM)};
        d    = make_desc(tbl, idx);
        pres = d[47];
        old_sel  = seg_sel;
        old_base = seg_base;
        mem_lat = lat;
        sel_in = sel;
        sel_wr = 1'b1;
        tick();
        sel_wr = 1'b0;
        if (rng_bad) begin
            chk(fault == 1'b1, "R3", "range fault pulse", fault, 1);
            chk(busy == 1'b0 && mem_req == 1'b0, "R3", "no request on range fault",
                {busy, mem_req}, 0);
            tick();
            chk(fault == 1'b0, "R3", "fault one cycle", fault, 0);
            chk(seg_sel == old_sel && seg_base == old_base, "R3", "cache kept",
                {seg_sel, seg_base}, {old_sel, old_base});
            return;
        end
        chk(busy == 1'b1, "R5", "busy after write", busy, 1);
        chk(mem_req && mem_addr == ent, "R2", "low word address", mem_addr, ent);
        got_done = 1'b0;
        got_fault = 1'b0;
        for (int i = 0; i < 100 && !got_done && !got_fault; i++) begin
            if (mem_req && mem_rvalid && mem_addr == ent + 4)
                chk(1'b1, "R2", "high word address", mem_addr, ent + 4);
            tick();
            got_done  = load_done;
            got_fault = fault;
            if (!got_done && !got_fault)
                chk(busy == 1'b1, "R5", "busy during load", busy, 1);
        end
        chk(busy == 1'b0, "R5", "busy low at end", busy, 0);
        if (!pres) begin
            chk(got_fault && !got_done, "R8", "not-present fault", {got_fault, got_done}, 2'b10);
            chk(seg_sel == old_sel && seg_base == old_base, "R8", "cache kept",
                {seg_sel, seg_base}, {old_sel, old_base});
        end else begin
            lim = {d[51:48], d[15:0]};
            chk(got_done && !got_fault, "R11", "load_done pulse", {got_done, got_fault}, 2'b10);
            chk(seg_sel == sel, "R1", "selector cached", seg_sel, sel);
            chk(seg_base == {d[63:56], d[39:16]}, "R6", "base", seg_base, {d[63:56], d[39:16]});
            chk(seg_limit == lim, "R6", "limit", seg_limit, lim);
            chk(seg_access == d[47:40], "R6", "access", seg_access, d[47:40]);
            chk(seg_flags == d[55:52], "R6", "flags", seg_flags, d[55:52]);
            chk(seg_dpl == d[46:45], "R8", "dpl", seg_dpl, d[46:45]);
            chk(seg_limit_eff == (d[55] ? {lim, 12'hFFF} : {12'h0, lim}), "R7",
                "effective limit", seg_limit_eff, d[55] ? {lim, 12'hFFF} : {12'h0, lim});
            tick();
            chk(load_done == 1'b0, "R11", "done one cycle", load_done, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] keep;
        repeat (3) tick();
        chk(!busy && !mem_req && !fault && !load_done, "R10", "control after reset",
            {busy, mem_req, fault, load_done}, 0);
        chk(seg_sel == 0 && seg_base == 0 && seg_limit == 0 && seg_access == 0 && seg_flags == 0,
            "R10", "cache after reset", {seg_sel, seg_base}, 0);
        rst_n = 1'b1;
        tick();

        for (int v = 0; v < NVEC; v++)
            run_load(VEC[v][19:4], int'(VEC[v][3:0]));

        // R9: write in the middle of a slow load
        mem_lat = 5;
        sel_in = 16'h000B;
        sel_wr = 1'b1;
        tick();
        sel_in = 16'h0010;
        tick();
        sel_wr = 1'b0;
        for (int i = 0; i < 50 && !load_done; i++) tick();
        chk(seg_sel == 16'h000B, "R9", "mid-load write dropped", seg_sel, 16'h000B);
        tick();
        chk(!mem_req && !busy, "R9", "no load after dropped write", {mem_req, busy}, 0);

        // R9: write in the same cycle the high word completes
        mem_lat = 2;
        keep = 16'h0034;
        sel_in = keep;
        sel_wr = 1'b1;
        tick();
        sel_wr = 1'b0;
        for (int i = 0; i < 50 && !(mem_rvalid && mem_addr == LBASE + 32'h30 + 4); i++) tick();
        sel_in = 16'h0008;
        sel_wr = 1'b1;
        tick();
        sel_wr = 1'b0;
        chk(load_done && !busy, "R9", "collision completes load", {load_done, busy}, 2'b10);
        chk(seg_sel == keep, "R9", "collision keeps selector", seg_sel, keep);
        tick();
        chk(!mem_req && !busy && !fault, "R9", "collision starts nothing",
            {mem_req, busy, fault}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule